// File: doc/BRIEF.md
# Two-level carry-lookahead adder

This block adds two unsigned 16-bit operands and a carry-in in pure combinational logic. It returns a 16-bit sum and a carry-out. The carries are not passed bit by bit along the word. Each bit position first reports whether it creates a carry by itself (generate) and whether it would pass on a carry that arrives from below (propagate). Propagate here is the OR of the two operand bits.

Four first-level lookahead blocks each summarise a four-bit slice into one group generate and one group propagate. A single second-level block folds those four summaries with the external carry-in and returns the carry that enters each slice. Each first-level block then expands its slice's incoming carry into the carries of its own bits. The sum bits come from the operand bits and those carries, and the final carry-out comes from the whole-word summary.

The block has no clock and holds no state. It is meant to sit inside a wider datapath wherever an address or operand sum has to settle within one cycle.

Top module: `lookahead_adder`

## Requirements
- R1: `sum` equals the low 16 bits of `opnd_a + opnd_b + carry_in`, taken as unsigned numbers, for every operand pair and carry-in value.
- R2: `carry_out` equals bit 16 of that same 17-bit sum, so it is 1 exactly when the true result exceeds 0xFFFF.
- R3: When every bit position has at least one operand bit set and `carry_in` is 1, the carry-in crosses all four slices. With `opnd_a` = 0xFFFF, `opnd_b` = 0 and `carry_in` = 1, the result is `sum` = 0x0000 with `carry_out` = 1.
- R4: A carry created inside one four-bit slice (bits 4k+3..4k) reaches the slice above it whatever the carry-in is. For example, 0x0008 + 0x0008 gives 0x0010.
- R5: A slice carries an incoming carry upward only if each of its bit positions has an operand bit set. A position where both operand bits are 0 stops the carry. For example, 0x00FF + 0 + 1 gives 0x0100, but 0x00EF + 0 + 1 gives 0x00F0.
- R6: The largest input, 0xFFFF + 0xFFFF + 1, gives `sum` = 0xFFFF with `carry_out` = 1.
- R7: The outputs depend only on the present inputs. Two different input sets applied within one clock period each produce their own correct result, with no clock edge between them.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opnd_a | input | 16 | First addend |
| opnd_b | input | 16 | Second addend |
| carry_in | input | 1 | Carry into bit 0 |
| sum | output | 16 | Low 16 bits of the result |
| carry_out | output | 1 | Carry out of bit 15 |

## Verification
Two functions can fall in the same evaluation. One is a carry generated inside a slice. The other is a carry-in propagated through a slice above it. The second-level block must merge both before it sets the carry into the next slice. The bench provokes this with an exhaustive sweep of the low byte of both operands while the upper byte is held fully propagating (0x5A with 0xA5). This makes every low-slice generate and the external carry-in compete for the same path to `carry_out`. Each result is judged against a 17-bit behavioural sum.

// File: rtl/lookahead_pkg.sv
// Package: lookahead_pkg
// Shared sizing for the two-level lookahead adder.
// Assumes the word width is an exact multiple of the slice span.
package lookahead_pkg;
    localparam int unsigned ADD_WIDTH  = 16;
    localparam int unsigned SLICE_SPAN = 4;
endpackage

// File: rtl/cla_bit_gp.sv
// Module: cla_bit_gp
// Forms a per-bit generate (AND) and propagate (OR) for every operand bit.
// Assumes nothing about the operands; it is purely combinational.
module cla_bit_gp #(
    parameter int unsigned WIDTH = lookahead_pkg::ADD_WIDTH
) (
    input  logic [WIDTH-1:0] opa,
    input  logic [WIDTH-1:0] opb,
    output logic [WIDTH-1:0] gen,
    output logic [WIDTH-1:0] prop
);
    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
        // Generate when both bits are set, propagate when either is set.
        assign gen[i]  = opa[i] & opb[i];
        assign prop[i] = opa[i] | opb[i];
    end
endmodule

// File: rtl/cla_lookahead.sv
// Module: cla_lookahead
// Reusable lookahead block with SPAN generate/propagate input pairs.
// From a base carry it returns the carry into every slot, each one as a flat
// window expression. It also summarises the whole window as one group
// generate and one group propagate.
// Assumes the group outputs never depend on the base carry, which keeps the
// upward and downward paths of the tree free of loops.
module cla_lookahead #(
    parameter int unsigned SPAN = lookahead_pkg::SLICE_SPAN
) (
    input  logic [SPAN-1:0] g_in,
    input  logic [SPAN-1:0] p_in,
    input  logic            c_base,
    output logic [SPAN-1:0] c_slot,
    output logic            g_win,
    output logic            p_win
);
    // Group generate of slots hi-1..0, as a sum of products.
    function automatic logic win_gen(input logic [SPAN-1:0] g,
                                     input logic [SPAN-1:0] p,
                                     input int unsigned hi);
        logic acc;
        logic term;
        acc = 1'b0;
        for (int unsigned j = 0; j < SPAN; j++) begin
            if (j < hi) begin
                term = g[j];
                for (int unsigned m = 0; m < SPAN; m++) begin
                    if (m > j && m < hi) term = term & p[m];
                end
                acc = acc | term;
            end
        end
        return acc;
    endfunction

    // Group propagate of slots hi-1..0.
    function automatic logic win_prop(input logic [SPAN-1:0] p,
                                      input int unsigned hi);
        logic acc;
        acc = 1'b1;
        for (int unsigned m = 0; m < SPAN; m++) begin
            if (m < hi) acc = acc & p[m];
        end
        return acc;
    endfunction

    // Carry into each slot, from the window below it and the base carry.
    always_comb begin
        for (int unsigned i = 0; i < SPAN; i++) begin
            c_slot[i] = win_gen(g_in, p_in, i) | (win_prop(p_in, i) & c_base);
        end
    end

    // Summary of the whole window, independent of the base carry.
    always_comb begin
        g_win = win_gen(g_in, p_in, SPAN);
        p_win = win_prop(p_in, SPAN);
    end
endmodule

// File: rtl/cla_sum.sv
// Module: cla_sum
// Forms each sum bit from its operand pair and the carry into that bit.
// Assumes the carries are already resolved by the lookahead tree.
module cla_sum #(
    parameter int unsigned WIDTH = lookahead_pkg::ADD_WIDTH
) (
    input  logic [WIDTH-1:0] opa,
    input  logic [WIDTH-1:0] opb,
    input  logic [WIDTH-1:0] cin_bits,
    output logic [WIDTH-1:0] sum_bits
);
    for (genvar i = 0; i < WIDTH; i++) begin : g_sum
        // Three-way exclusive OR per bit.
        assign sum_bits[i] = opa[i] ^ opb[i] ^ cin_bits[i];
    end
endmodule

// File: rtl/lookahead_adder.sv
// Module: lookahead_adder
// Two-level carry-lookahead adder. Bit generate/propagate feeds one
// first-level block per slice. The slice summaries feed a single
// second-level block, which returns the carry into each slice.
// The carry-out comes from the whole-word summary.
// Assumes WIDTH = SPAN * number of slices, with no more slices than one
// lookahead block can take. No clock and no state.
module lookahead_adder #(
    parameter int unsigned WIDTH = lookahead_pkg::ADD_WIDTH,
    parameter int unsigned SPAN  = lookahead_pkg::SLICE_SPAN
) (
    input  logic [WIDTH-1:0] opnd_a,
    input  logic [WIDTH-1:0] opnd_b,
    input  logic             carry_in,
    output logic [WIDTH-1:0] sum,
    output logic             carry_out
);
    localparam int unsigned NGRP = WIDTH / SPAN;

    logic [WIDTH-1:0] bit_g;
    logic [WIDTH-1:0] bit_p;
    logic [WIDTH-1:0] bit_c;
    logic [NGRP-1:0]  grp_g;
    logic [NGRP-1:0]  grp_p;
    logic [NGRP-1:0]  grp_cin;
    logic             word_g;
    logic             word_p;

    cla_bit_gp #(.WIDTH(WIDTH)) u_gp (
        .opa  (opnd_a),
        .opb  (opnd_b),
        .gen  (bit_g),
        .prop (bit_p)
    );

    // First level: one lookahead block per slice.
    for (genvar k = 0; k < NGRP; k++) begin : g_slice
        cla_lookahead #(.SPAN(SPAN)) u_lvl1 (
            .g_in   (bit_g[k*SPAN +: SPAN]),
            .p_in   (bit_p[k*SPAN +: SPAN]),
            .c_base (grp_cin[k]),
            .c_slot (bit_c[k*SPAN +: SPAN]),
            .g_win  (grp_g[k]),
            .p_win  (grp_p[k])
        );
    end

    // Second level: the same block over the slice summaries.
    cla_lookahead #(.SPAN(NGRP)) u_lvl2 (
        .g_in   (grp_g),
        .p_in   (grp_p),
        .c_base (carry_in),
        .c_slot (grp_cin),
        .g_win  (word_g),
        .p_win  (word_p)
    );

    // Carry out of the whole word from its summary.
    assign carry_out = word_g | (word_p & carry_in);

    cla_sum #(.WIDTH(WIDTH)) u_sum (
        .opa      (opnd_a),
        .opb      (opnd_b),
        .cin_bits (bit_c),
        .sum_bits (sum)
    );
endmodule

// File: rtl/lookahead_adder_chk.sv
// Module: lookahead_adder_chk
// Checker bound into lookahead_adder. It compares the outputs and the slice
// summaries and carries against behavioural arithmetic.
// Assumes combinational settling before each always_comb evaluation.
module lookahead_adder_chk #(
    parameter int unsigned WIDTH = 16,
    parameter int unsigned SPAN  = 4
) (
    input logic [WIDTH-1:0]      opnd_a,
    input logic [WIDTH-1:0]      opnd_b,
    input logic                  carry_in,
    input logic [WIDTH-1:0]      sum,
    input logic                  carry_out,
    input logic [WIDTH/SPAN-1:0] grp_g,
    input logic [WIDTH/SPAN-1:0] grp_p,
    input logic [WIDTH/SPAN-1:0] grp_cin
);
    localparam int unsigned NGRP = WIDTH / SPAN;

    // Sum of one slice's operand bits, with no carry-in.
    function automatic logic [SPAN:0] slice_sum(input logic [WIDTH-1:0] a,
                                                input logic [WIDTH-1:0] b,
                                                input int unsigned k);
        return {1'b0, a[k*SPAN +: SPAN]} + {1'b0, b[k*SPAN +: SPAN]};
    endfunction

    // Behavioural carry into bit position pos.
    function automatic logic carry_at(input logic [WIDTH-1:0] a,
                                      input logic [WIDTH-1:0] b,
                                      input logic c,
                                      input int unsigned pos);
        logic [WIDTH:0] mask;
        logic [WIDTH:0] s;
        mask = ({{WIDTH{1'b0}}, 1'b1} << pos) - 1'b1;
        s = ({1'b0, a} & mask) + ({1'b0, b} & mask) + {{WIDTH{1'b0}}, c};
        return s[pos];
    endfunction

    logic [WIDTH:0] ref_total;

    // Full-word checks against the unsigned reference sum.
    always_comb begin
        ref_total = {1'b0, opnd_a} + {1'b0, opnd_b} + {{WIDTH{1'b0}}, carry_in};
        a_r1_sum_value: assert (sum == ref_total[WIDTH-1:0])
            else $error("sum mismatch");
        a_r2_carry_out: assert (carry_out == ref_total[WIDTH])
            else $error("carry_out mismatch");
        a_r3_full_chain: assert (!((&(opnd_a | opnd_b)) && carry_in) || carry_out)
            else $error("full propagate chain lost the carry");
    end

    // Slice-level checks on the summaries and the carries sent down.
    always_comb begin
        for (int unsigned k = 0; k < NGRP; k++) begin
            a_r4_group_generate: assert (grp_g[k] == slice_sum(opnd_a, opnd_b, k)[SPAN])
                else $error("slice generate wrong");
            a_r5_group_propagate: assert (!grp_p[k] ||
                    (slice_sum(opnd_a, opnd_b, k) >= (SPAN+1)'((1 << SPAN) - 1)))
                else $error("slice propagate wrong");
            a_r5_slice_carry_in: assert (grp_cin[k] ==
                    carry_at(opnd_a, opnd_b, carry_in, k*SPAN))
                else $error("carry into slice wrong");
        end
    end
endmodule

bind lookahead_adder lookahead_adder_chk #(.WIDTH(WIDTH), .SPAN(SPAN)) u_chk (
    .opnd_a    (opnd_a),
    .opnd_b    (opnd_b),
    .carry_in  (carry_in),
    .sum       (sum),
    .carry_out (carry_out),
    .grp_g     (grp_g),
    .grp_p     (grp_p),
    .grp_cin   (grp_cin)
);

// File: tb/sim_lookahead_adder.sv
`timescale 1ns/1ps
// Bench for lookahead_adder. Directed scenarios, one task each, checking
// results against a 17-bit behavioural sum or hand-worked constants.
module sim_lookahead_adder;
    logic        clk = 1'b0;
    logic [15:0] opnd_a = '0;
    logic [15:0] opnd_b = '0;
    logic        carry_in = 1'b0;
    logic [15:0] sum;
    logic        carry_out;
    int          n_chk = 0;
    int          n_bad = 0;
    bit          done = 1'b0;

    always #2.5 clk = ~clk;

    lookahead_adder u0 (
        .opnd_a    (opnd_a),
        .opnd_b    (opnd_b),
        .carry_in  (carry_in),
        .sum       (sum),
        .carry_out (carry_out)
    );

    // Apply a vector, let it settle and compare with given expected values.
    task automatic expect_vec(input logic [15:0] a, input logic [15:0] b,
                              input logic ci, input logic [15:0] exp_s,
                              input logic exp_c, input string req);
        opnd_a = a; opnd_b = b; carry_in = ci;
        #1;
        n_chk++;
        if (sum !== exp_s || carry_out !== exp_c) begin
            n_bad++;
            $display("FAIL %s: a=%h b=%h ci=%0d got %h/%0d expected %h/%0d",
                     req, a, b, ci, sum, carry_out, exp_s, exp_c);
        end
    endtask

    // Apply a vector and compare with the behavioural sum.
    task automatic check_ref(input logic [15:0] a, input logic [15:0] b,
                             input logic ci, input string req);
        logic [16:0] t;
        t = {1'b0, a} + {1'b0, b} + {16'd0, ci};
        expect_vec(a, b, ci, t[15:0], t[16], req);
    endtask

    // R1 R2: all-zero inputs give a zero result.
    task automatic t_zero();
        expect_vec(16'h0000, 16'h0000, 1'b0, 16'h0000, 1'b0, "R1");
        expect_vec(16'h0000, 16'h0000, 1'b1, 16'h0001, 1'b0, "R2");
    endtask

    // R3: carry-in runs through every slice.
    task automatic t_full_chain();
        expect_vec(16'hFFFF, 16'h0000, 1'b1, 16'h0000, 1'b1, "R3");
        expect_vec(16'h0000, 16'hFFFF, 1'b1, 16'h0000, 1'b1, "R3");
        expect_vec(16'hF0F0, 16'h0F0F, 1'b1, 16'h0000, 1'b1, "R3");
        expect_vec(16'hFFFF, 16'h0000, 1'b0, 16'hFFFF, 1'b0, "R3");
    endtask

    // R4: a carry generated in each slice reaches the next one up.
    task automatic t_group_generate();
        expect_vec(16'h0008, 16'h0008, 1'b0, 16'h0010, 1'b0, "R4");
        expect_vec(16'h0080, 16'h0080, 1'b1, 16'h0101, 1'b0, "R4");
        expect_vec(16'h0800, 16'h0800, 1'b0, 16'h1000, 1'b0, "R4");
        expect_vec(16'h8000, 16'h8000, 1'b0, 16'h0000, 1'b1, "R4");
        expect_vec(16'h000F, 16'h0001, 1'b0, 16'h0010, 1'b0, "R4");
    endtask

    // R5: a slice with a zero-zero position stops the incoming carry.
    task automatic t_kill();
        expect_vec(16'h00FF, 16'h0000, 1'b1, 16'h0100, 1'b0, "R5");
        expect_vec(16'h00EF, 16'h0000, 1'b1, 16'h00F0, 1'b0, "R5");
        expect_vec(16'hFF7F, 16'h0000, 1'b1, 16'hFF80, 1'b0, "R5");
        expect_vec(16'h0F00, 16'h00F0, 1'b1, 16'h0FF1, 1'b0, "R5");
    endtask

    // R6: largest operands with carry-in.
    task automatic t_max();
        expect_vec(16'hFFFF, 16'hFFFF, 1'b1, 16'hFFFF, 1'b1, "R6");
        expect_vec(16'hFFFF, 16'hFFFF, 1'b0, 16'hFFFE, 1'b1, "R6");
    endtask

    // R7: two vectors inside one clock period, no edge between them.
    task automatic t_no_clock();
        @(negedge clk);
        expect_vec(16'h1234, 16'h4321, 1'b0, 16'h5555, 1'b0, "R7");
        expect_vec(16'h8001, 16'h7FFF, 1'b0, 16'h0000, 1'b1, "R7");
    endtask

    // R1 R2: exhaustive low byte over a fully propagating upper byte.
    task automatic t_low_sweep();
        for (int x = 0; x < 256; x++) begin
            for (int y = 0; y < 256; y++) begin
                for (int c = 0; c < 2; c++) begin
                    check_ref({8'h5A, 8'(x)}, {8'hA5, 8'(y)}, 1'(c), "R1/R2 sweep");
                end
            end
        end
    endtask

    // R1 R2: pseudo-random operands across the whole word.
    task automatic t_random();
        for (int i = 0; i < 2000; i++) begin
            check_ref(16'($urandom), 16'($urandom), 1'($urandom), "R1/R2 random");
        end
    endtask

    // Watchdog: a hung run counts as a failed check.
    initial begin
        #900000;
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: run did not complete, got hang expected finish");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    // Main sequence.
    initial begin
        @(negedge clk);
        t_zero();
        t_full_chain();
        t_group_generate();
        t_kill();
        t_max();
        t_no_clock();
        t_low_sweep();
        t_random();
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule